// File: doc/BRIEF.md
# Calendar Clock With Format Modes

This block is the timekeeping core of a real-time clock. It keeps seconds, minutes, hours, day of week, date, month and a two-digit year, together with a seconds, minutes and hours alarm. A host reaches all of them through a byte-wide register port. A one-pulse-per-second tick advances the time by one second. At each advance the new time is compared against the alarm bytes, and a match raises a sticky alarm flag.

All stored bytes use a single encoding, chosen by a control bit: packed two-digit BCD or plain binary. Hours are kept in either 24-hour form or 12-hour form with a PM marker. The block does not convert stored bytes when the host changes either mode, so the host re-initialises the affected bytes after such a change. To load a time safely, the host sets a freeze bit, writes the bytes and then clears the bit. Host accesses never wait for an update. A tick that arrives in the same cycle as a host write is held for one cycle and then applied.

The register map is as follows:

| Address | Contents |
|---|---|
| 0 | seconds |
| 1 | minutes |
| 2 | hours |
| 3 | day of week |
| 4 | date |
| 5 | month |
| 6 | year |
| 7 | alarm seconds |
| 8 | alarm minutes |
| 9 | alarm hours |
| 10 | control |
| 11 | status |

The control bits are bit0 freeze, bit1 binary mode and bit2 24-hour mode. Status bit0 is the alarm flag.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the port reads the following values:

  | Byte | Value |
  |---|---|
  | seconds, minutes, hours | 0x00 |
  | day of week, date, month | 0x01 |
  | year | 0x00 |
  | each alarm byte | 0xFF |
  | control (address 10) | 0x04: BCD, 24-hour, not frozen |
  | status (address 11) | 0x00 |

- R2: Each accepted tick adds one second. Seconds wrap 59 to 00 and carry into minutes. Minutes wrap 59 to 00 and carry into hours. In BCD mode (control bit1 = 0) a value is stored as tens in bits 7:4 and units in bits 3:0.
- R3: In binary mode (control bit1 = 1) every byte counts identically, but holds the plain binary value.
- R4: In 24-hour mode (control bit2 = 1) hours run 0 to 23 and wrap to 0, which is midnight.
- R5: In 12-hour mode (control bit2 = 0) hours behave as follows:
  - Bit 7 of the hours byte is 1 for PM, and bits 6:0 hold 1 to 12.
  - The step from 11 to 12 toggles PM.
  - The step from 12 to 1 keeps PM unchanged.
  - 11 PM to 12 AM is midnight.
- R6: Day of week counts 1 to 7 (1 = Sunday), advances at midnight and wraps from 7 to 1.
- R7: The date wraps to 1 after the last day of the month: 30 for April, June, September and November; 31 for the other long months; and 29 for February when the year is a multiple of 4, 28 otherwise.
- R8: When the date wraps, the month advances. Month 12 wraps to 1 and advances the year. Year 99 wraps to 00.
- R9: While control bit0 (freeze) is 1, ticks are discarded and no time byte changes.
- R10: An update whose new seconds, minutes and hours bytes all equal the three alarm bytes sets the alarm flag, visible on `alarm_flag` and at status bit0. The flag stays set until the status register is read. That read returns 1 and clears the flag.
- R11: Writing the control mode bits leaves every stored time byte unchanged; no re-encoding takes place.
- R12: A tick in the same cycle as a host write is not lost. The write is stored, and the tick is applied to the result one cycle later. `rdata` holds the addressed register one cycle after `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| tick_1hz | input | 1 | one-cycle pulse, once per second |
| wr_en | input | 1 | host write strobe |
| rd_en | input | 1 | host read strobe |
| addr | input | ADDR_W | register address |
| wdata | input | 8 | write data |
| rdata | output | 8 | registered read data |
| alarm_flag | output | 1 | sticky alarm match flag |

## Verification
The bench builds the block with its default parameters:
- ADDR_W = 4
- YEAR_TOP = 99
- ALARM_INIT = 0xFF

With YEAR_TOP at 99, a single tick from 23:59:59 on 31 December 99 ripples a carry through every counter at once. With ALARM_INIT at 0xFF, an alarm can never match before the host programs it. Directed cases cover every month length, leap and common Februaries, and each 12-hour PM transition in both encodings. Random times, biased toward field limits, are loaded in random modes and then ticked.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int BYTE_W    = 8;
  localparam int NUM_BYTES = 10;
  localparam int ADR_SEC   = 0;
  localparam int ADR_MIN   = 1;
  localparam int ADR_HOUR  = 2;
  localparam int ADR_DOW   = 3;
  localparam int ADR_DATE  = 4;
  localparam int ADR_MONTH = 5;
  localparam int ADR_YEAR  = 6;
  localparam int ADR_ASEC  = 7;
  localparam int ADR_AMIN  = 8;
  localparam int ADR_AHOUR = 9;
  localparam int ADR_CTRL  = 10;
  localparam int ADR_STAT  = 11;

  // stored byte -> binary value
  function automatic logic [7:0] fmt_to_bin(input logic [7:0] x, input logic bin_mode);
    logic [7:0] tens;
    logic [7:0] units;
    tens  = {4'b0, x[7:4]};
    units = {4'b0, x[3:0]};
    return bin_mode ? x : (tens * 8'd10 + units);
  endfunction

  // binary value (< 100) -> stored byte
  function automatic logic [7:0] bin_to_fmt(input logic [7:0] v, input logic bin_mode);
    logic [3:0] tens;
    logic [3:0] units;
    tens  = 4'(v / 8'd10);
    units = 4'(v % 8'd10);
    return bin_mode ? v : {tens, units};
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] mo, input logic [7:0] yr);
    case (mo)
      8'd2:                        return (yr[1:0] == 2'b00) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:     return 8'd30;
      default:                     return 8'd31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_field_step.sv
module rtc_field_step
  import rtc_cal_pkg::*;
#(
  parameter logic [7:0] FIRST = 8'd0
) (
  input  logic [7:0] cur,
  input  logic [7:0] last,
  input  logic       bin_mode,
  input  logic       inc,
  output logic [7:0] nxt,
  output logic       carry
);
  logic [7:0] val;

  always_comb begin
    val   = fmt_to_bin(cur, bin_mode);
    nxt   = cur;
    carry = 1'b0;
    if (inc) begin
      if (val >= last) begin
        nxt   = bin_to_fmt(FIRST, bin_mode);
        carry = 1'b1;
      end else begin
        nxt = bin_to_fmt(val + 8'd1, bin_mode);
      end
    end
  end
endmodule

// File: rtl/rtc_hour_step.sv
module rtc_hour_step
  import rtc_cal_pkg::*;
#(
  parameter int HOURS_DAY = 24
) (
  input  logic [7:0] cur,
  input  logic       h24,
  input  logic       bin_mode,
  input  logic       inc,
  output logic [7:0] nxt,
  output logic       carry
);
  localparam logic [7:0] LAST_24 = 8'(HOURS_DAY - 1);
  localparam logic [7:0] HALF    = 8'(HOURS_DAY / 2);

  logic [7:0] val;
  logic [7:0] enc;
  logic [7:0] nv;
  logic       pm_n;

  always_comb begin
    nxt   = cur;
    carry = 1'b0;
    nv    = 8'd0;
    pm_n  = cur[7];
    enc   = 8'd0;
    if (h24) begin
      val = fmt_to_bin(cur, bin_mode);
      if (inc) begin
        if (val >= LAST_24) begin
          nxt   = 8'd0;
          carry = 1'b1;
        end else begin
          nxt = bin_to_fmt(val + 8'd1, bin_mode);
        end
      end
    end else begin
      val = fmt_to_bin({1'b0, cur[6:0]}, bin_mode);
      if (val >= HALF) begin
        nv = 8'd1;
      end else if (val == HALF - 8'd1) begin
        nv    = HALF;
        pm_n  = ~cur[7];
        carry = inc & cur[7];
      end else begin
        nv = val + 8'd1;
      end
      enc = bin_to_fmt(nv, bin_mode);
      if (inc) nxt = {pm_n, 7'b0} | enc;
    end
  end
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match (
  input  logic [7:0] sec_n,
  input  logic [7:0] min_n,
  input  logic [7:0] hour_n,
  input  logic [7:0] al_sec,
  input  logic [7:0] al_min,
  input  logic [7:0] al_hour,
  input  logic       upd,
  output logic       hit
);
  always_comb hit = upd && (sec_n == al_sec) && (min_n == al_min) && (hour_n == al_hour);
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_cal_pkg::*;
#(
  parameter int         ADDR_W     = 4,
  parameter int         YEAR_TOP   = 99,
  parameter logic [7:0] ALARM_INIT = 8'hFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_1hz,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              alarm_flag
);
  localparam int IDX_W = $clog2(NUM_BYTES);
  localparam int NUM_TIME = 7;

  logic [7:0] regs_q [NUM_BYTES];
  logic       frz_q, bin_q, h24_q, pend_q, flag_q;
  logic       do_upd, hit;
  logic       is_byte, is_ctrl, is_stat;
  logic [IDX_W-1:0] idx;

  logic [7:0] sm_n [2];
  logic       sm_c [2];
  logic [7:0] hour_n, dow_n, date_n, mon_n, year_n;
  logic       day_c, dow_c, date_c, mon_c, year_c;
  logic [7:0] mon_bin, year_bin, dlast;

  assign is_byte = addr < ADDR_W'(NUM_BYTES);
  assign is_ctrl = addr == ADDR_W'(ADR_CTRL);
  assign is_stat = addr == ADDR_W'(ADR_STAT);
  assign idx     = addr[IDX_W-1:0];

  // a tick colliding with a host write is held one cycle
  assign do_upd = (tick_1hz | pend_q) & ~wr_en & ~frz_q;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= 1'b0;
    else     pend_q <= (tick_1hz | pend_q) & wr_en & ~frz_q;
  end

  // seconds and minutes share one 0..59 stepper shape
  for (genvar g = 0; g < 2; g++) begin : g_sm
    rtc_field_step #(.FIRST(8'd0)) u_step (
      .cur(regs_q[g]), .last(8'd59), .bin_mode(bin_q),
      .inc((g == 0) ? do_upd : sm_c[0]),
      .nxt(sm_n[g]), .carry(sm_c[g])
    );
  end

  rtc_hour_step #(.HOURS_DAY(24)) u_hour (
    .cur(regs_q[ADR_HOUR]), .h24(h24_q), .bin_mode(bin_q), .inc(sm_c[1]),
    .nxt(hour_n), .carry(day_c)
  );

  rtc_field_step #(.FIRST(8'd1)) u_dow (
    .cur(regs_q[ADR_DOW]), .last(8'd7), .bin_mode(bin_q), .inc(day_c),
    .nxt(dow_n), .carry(dow_c)
  );

  assign mon_bin  = fmt_to_bin(regs_q[ADR_MONTH], bin_q);
  assign year_bin = fmt_to_bin(regs_q[ADR_YEAR], bin_q);
  assign dlast    = month_len(mon_bin, year_bin);

  rtc_field_step #(.FIRST(8'd1)) u_date (
    .cur(regs_q[ADR_DATE]), .last(dlast), .bin_mode(bin_q), .inc(day_c),
    .nxt(date_n), .carry(date_c)
  );

  rtc_field_step #(.FIRST(8'd1)) u_month (
    .cur(regs_q[ADR_MONTH]), .last(8'd12), .bin_mode(bin_q), .inc(date_c),
    .nxt(mon_n), .carry(mon_c)
  );

  rtc_field_step #(.FIRST(8'd0)) u_year (
    .cur(regs_q[ADR_YEAR]), .last(8'(YEAR_TOP)), .bin_mode(bin_q), .inc(mon_c),
    .nxt(year_n), .carry(year_c)
  );

  rtc_alarm_match u_alarm (
    .sec_n(sm_n[0]), .min_n(sm_n[1]), .hour_n(hour_n),
    .al_sec(regs_q[ADR_ASEC]), .al_min(regs_q[ADR_AMIN]), .al_hour(regs_q[ADR_AHOUR]),
    .upd(do_upd), .hit(hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_BYTES; i++) regs_q[i] <= (i >= NUM_TIME) ? ALARM_INIT : 8'd0;
      regs_q[ADR_DOW]   <= 8'd1;
      regs_q[ADR_DATE]  <= 8'd1;
      regs_q[ADR_MONTH] <= 8'd1;
    end else begin
      if (do_upd) begin
        regs_q[ADR_SEC]   <= sm_n[0];
        regs_q[ADR_MIN]   <= sm_n[1];
        regs_q[ADR_HOUR]  <= hour_n;
        regs_q[ADR_DOW]   <= dow_n;
        regs_q[ADR_DATE]  <= date_n;
        regs_q[ADR_MONTH] <= mon_n;
        regs_q[ADR_YEAR]  <= year_n;
      end
      if (wr_en && is_byte) regs_q[idx] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frz_q <= 1'b0;
      bin_q <= 1'b0;
      h24_q <= 1'b1;
    end else if (wr_en && is_ctrl) begin
      frz_q <= wdata[0];
      bin_q <= wdata[1];
      h24_q <= wdata[2];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                  flag_q <= 1'b0;
    else if (hit)             flag_q <= 1'b1;
    else if (rd_en && is_stat) flag_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= 8'd0;
    else if (rd_en) begin
      if (is_byte)      rdata <= regs_q[idx];
      else if (is_ctrl) rdata <= {5'b0, h24_q, bin_q, frz_q};
      else if (is_stat) rdata <= {7'b0, flag_q};
      else              rdata <= 8'd0;
    end
  end

  assign alarm_flag = flag_q;

  // R9: frozen and no host write -> time bytes hold
  assert_freeze_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (frz_q && !wr_en) |=> ($stable(regs_q[ADR_SEC]) && $stable(regs_q[ADR_YEAR])));
  // R2: a seconds carry leaves seconds at zero
  assert_sec_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    sm_c[0] |=> (regs_q[ADR_SEC] == 8'd0));
  // R6: day-of-week wraps to Sunday
  assert_dow_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    dow_c |=> (regs_q[ADR_DOW] == 8'd1));
  // R7: date wraps to the first
  assert_date_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    date_c |=> (regs_q[ADR_DATE] == 8'd1));
  // R8: year wraps to zero
  assert_year_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    year_c |=> (regs_q[ADR_YEAR] == 8'd0));
  // R10: match raises the flag
  assert_flag_set_R10: assert property (@(posedge clk) disable iff (rst)
    hit |=> alarm_flag);
  // R10: status read without a new match clears it
  assert_flag_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && is_stat && !hit) |=> !alarm_flag);
endmodule

// File: tb/sim_rtc_calendar_core.sv
`timescale 1ns/1ps
module sim_rtc_calendar_core;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_1hz = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [3:0] addr = 4'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       alarm_flag;

  int n_chk = 0;
  int n_err = 0;

  // model state
  int s, m, h, dw, dt, mo, yr;
  bit bm, m24, exp_flag;
  bit [7:0] a_s, a_m, a_h;

  rtc_calendar_core u0 (
    .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .alarm_flag(alarm_flag)
  );

  always #2.5 clk = ~clk;

  function automatic int dim(int mon, int year);
    if (mon == 2) return (year % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  function automatic bit [7:0] enc(int v);
    if (bm) return 8'(v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic bit [7:0] hbyte(int hh);
    int k;
    if (m24) return enc(hh);
    k = hh % 12;
    if (k == 0) k = 12;
    return ((hh >= 12) ? 8'h80 : 8'h00) | enc(k);
  endfunction

  function automatic bit [7:0] ctrl_byte(bit frz);
    return {5'b0, m24, bm, frz};
  endfunction

  task automatic step_model();
    s++;
    if (s == 60) begin
      s = 0; m++;
      if (m == 60) begin
        m = 0; h++;
        if (h == 24) begin
          h = 0;
          dw = (dw == 7) ? 1 : dw + 1;
          dt++;
          if (dt > dim(mo, yr)) begin
            dt = 1; mo++;
            if (mo == 13) begin
              mo = 1;
              yr = (yr == 99) ? 0 : yr + 1;
            end
          end
        end
      end
    end
    if (enc(s) == a_s && enc(m) == a_m && hbyte(h) == a_h) exp_flag = 1'b1;
  endtask

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = 4'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = 4'(a);
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic tick_raw();
    @(negedge clk);
    tick_1hz = 1'b1;
    @(negedge clk);
    tick_1hz = 1'b0;
  endtask

  task automatic tick();
    tick_raw();
    step_model();
  endtask

  task automatic load_all();
    wr(10, ctrl_byte(1'b1));
    wr(0, enc(s)); wr(1, enc(m)); wr(2, hbyte(h)); wr(3, enc(dw));
    wr(4, enc(dt)); wr(5, enc(mo)); wr(6, enc(yr));
    wr(7, a_s); wr(8, a_m); wr(9, a_h);
    wr(10, ctrl_byte(1'b0));
  endtask

  task automatic check_all(string req);
    logic [7:0] d;
    rd(0, d); chk({req, " seconds"}, d, enc(s));
    rd(1, d); chk({req, " minutes"}, d, enc(m));
    rd(2, d); chk({req, " hours"},   d, hbyte(h));
    rd(3, d); chk({req, " dow"},     d, enc(dw));
    rd(4, d); chk({req, " date"},    d, enc(dt));
    rd(5, d); chk({req, " month"},   d, enc(mo));
    rd(6, d); chk({req, " year"},    d, enc(yr));
  endtask

  task automatic set_time(int ss, int mm, int hh, int ww, int dd, int mn, int yy);
    s = ss; m = mm; h = hh; dw = ww; dt = dd; mo = mn; yr = yy;
  endtask

  initial begin
    #(200000 * 5);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int unused_seed;
    unused_seed = $urandom(32'h5eed);
    bm = 0; m24 = 1; exp_flag = 0;
    a_s = 8'hFF; a_m = 8'hFF; a_h = 8'hFF;
    set_time(0, 0, 0, 1, 1, 1, 0);
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset values
    rd(10, d); chk("R1 control", d, 8'h04);
    rd(11, d); chk("R1 status", d, 8'h00);
    rd(9, d);  chk("R1 alarm hours", d, 8'hFF);
    check_all("R1");

    // R2 R4 R6 R7 R8: full ripple in BCD 24-hour
    set_time(59, 59, 23, 7, 31, 12, 99);
    load_all();
    tick();
    check_all("R2 R4 R6 R8 ripple");

    // R7 month lengths
    set_time(59, 59, 23, 3, 28, 2, 24); load_all(); tick(); check_all("R7 leap 28feb");
    set_time(59, 59, 23, 3, 29, 2, 24); load_all(); tick(); check_all("R7 leap 29feb");
    set_time(59, 59, 23, 3, 28, 2, 23); load_all(); tick(); check_all("R7 common feb");
    set_time(59, 59, 23, 3, 30, 4, 23); load_all(); tick(); check_all("R7 april end");
    set_time(59, 59, 23, 3, 30, 7, 23); load_all(); tick(); check_all("R7 july 30");

    // R3 binary mode
    bm = 1;
    set_time(59, 59, 23, 6, 31, 1, 45); load_all(); tick(); check_all("R3 binary");
    set_time(59, 59, 23, 6, 31, 12, 99); load_all(); tick(); check_all("R3 binary ripple");

    // R5 twelve-hour mode, both encodings
    for (int e = 0; e < 2; e++) begin
      bm = e[0]; m24 = 0;
      set_time(59, 59, 11, 2, 10, 5, 30); load_all(); tick(); check_all("R5 11am to 12pm");
      set_time(59, 59, 12, 2, 10, 5, 30); load_all(); tick(); check_all("R5 12pm to 1pm");
      set_time(59, 59, 23, 2, 10, 5, 30); load_all(); tick(); check_all("R5 midnight");
      set_time(59, 59, 0, 2, 10, 5, 30);  load_all(); tick(); check_all("R5 12am to 1am");
    end
    bm = 0; m24 = 1;

    // R9 freeze
    set_time(58, 59, 23, 7, 31, 12, 99); load_all();
    wr(10, ctrl_byte(1'b1));
    repeat (3) tick_raw();
    check_all("R9 frozen");
    wr(10, ctrl_byte(1'b0));
    tick();
    check_all("R9 resumed");

    // R11 mode change leaves bytes
    set_time(35, 12, 9, 4, 17, 8, 41); load_all();
    wr(10, {5'b0, 1'b0, 1'b1, 1'b1});
    rd(0, d); chk("R11 seconds kept", d, 8'h35);
    rd(2, d); chk("R11 hours kept", d, 8'h09);
    wr(10, {5'b0, 1'b1, 1'b0, 1'b0});
    rd(4, d); chk("R11 date kept", d, 8'h17);

    // R10 alarm
    bm = 0; m24 = 1;
    set_time(29, 30, 10, 4, 17, 8, 41);
    a_s = enc(30); a_m = enc(30); a_h = hbyte(10);
    exp_flag = 0;
    load_all();
    @(negedge clk); chk("R10 flag before match", {7'b0, alarm_flag}, 8'h00);
    tick();
    chk("R10 flag port", {7'b0, alarm_flag}, {7'b0, exp_flag});
    tick();
    chk("R10 flag held", {7'b0, alarm_flag}, 8'h01);
    rd(11, d); chk("R10 status read", d, 8'h01);
    chk("R10 flag cleared", {7'b0, alarm_flag}, 8'h00);
    rd(11, d); chk("R10 status after clear", d, 8'h00);
    exp_flag = 0;

    // R12 tick collides with a host write
    set_time(5, 20, 14, 2, 3, 3, 50); load_all();
    @(negedge clk);
    wr_en = 1'b1; addr = 4'd0; wdata = enc(10); tick_1hz = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick_1hz = 1'b0;
    s = 10; step_model();
    @(negedge clk);
    rd(0, d); chk("R12 write then deferred tick", d, enc(11));

    // random times and modes
    for (int it = 0; it < 60; it++) begin
      int nt;
      bm  = $urandom % 2;
      m24 = $urandom % 2;
      yr = ($urandom % 3 == 0) ? 99 : $urandom % 100;
      mo = ($urandom % 3 == 0) ? 12 : 1 + $urandom % 12;
      dt = ($urandom % 2 == 0) ? dim(mo, yr) : 1 + $urandom % dim(mo, yr);
      dw = 1 + $urandom % 7;
      h  = ($urandom % 2 == 0) ? (($urandom % 2 == 0) ? 23 : 11) : $urandom % 24;
      m  = ($urandom % 2 == 0) ? 59 : $urandom % 60;
      s  = ($urandom % 2 == 0) ? 58 + $urandom % 2 : $urandom % 60;
      exp_flag = 0;
      if ($urandom % 2 == 0) begin
        int ss, mm, hh;
        ss = s + 1; mm = m; hh = h;
        if (ss == 60) begin
          ss = 0; mm++;
          if (mm == 60) begin mm = 0; hh = (hh + 1) % 24; end
        end
        a_s = enc(ss); a_m = enc(mm); a_h = hbyte(hh);
      end else begin
        a_s = 8'hFF; a_m = 8'hFF; a_h = 8'hFF;
      end
      load_all();
      nt = 1 + $urandom % 4;
      for (int k = 0; k < nt; k++) tick();
      check_all("R2 R3 R4 R5 R6 R7 R8 random");
      rd(11, d); chk("R10 random status", d, {7'b0, exp_flag});
    end

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule